// File: doc/BRIEF.md
# Multiplexed Latching Bus Exchanger

This block joins one shared bidirectional data port, A, to two bidirectional ports, B1 and B2. It can fan a single stream out into two banks, for example B1 for the even memory bank and B2 for the odd bank. It can also merge the two banks back onto the shared port. Two forward storage elements carry data from A toward B1 and B2. Two return storage elements carry data from B1 and B2 toward A, and a select input picks which return element drives A.

Each storage element behaves as a level-sensitive latch made from a clocked register. While its enable is high, it takes the resolved pin level on every clock edge. When the enable goes low, it keeps the value taken on the last edge with the enable high.

Every pin is modelled as three signals: an incoming value, an outgoing value and an output-enable. Each pin also has an external-drive flag. A bus keeper on each pin holds the last resolved level whenever neither the outside world nor the block drives the pin. The keeper clears to zero on the synchronous reset. The storage registers have no reset.

Top module: `mux_latch_exchanger`

## Requirements
- R1: While `le_a_to_b1` is high at a clock edge, `b1_out` shows, after that edge, the level port A had just before the edge.
- R2: While a storage element's enable is low at a clock edge, its output keeps its previous value, whatever its source pin does.
- R3: The two forward elements are independent: loading the A-to-B2 element leaves `b1_out` unchanged.
- R4: With `sel` = 1, `a_out` shows the B1-to-A element. With `sel` = 0, it shows the B2-to-A element. The change is visible in the same cycle that `sel` changes.
- R5: The enables `a_oe_n`, `b1_oe_n` and `b2_oe_n` are active low, and each one is independent. Each pin's `*_oe` equals the inverse of its enable, so neither bank, either bank alone, or both banks can drive.
- R6: When a pin is driven neither externally (`*_drv_ext` = 0) nor by the block (`*_oe` = 0), its resolved level is the last resolved level. The keeper holds 0 after reset.
- R7: When the block drives a pin and nothing external does, the resolved level of that pin is the block's own output value. The keeper retains that value after the block releases the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (keepers only) |
| sel | input | 1 | 1: A driven from B1 path, 0: from B2 path |
| le_a_to_b1 | input | 1 | Enable of A-to-B1 storage, high = transparent |
| le_a_to_b2 | input | 1 | Enable of A-to-B2 storage |
| le_b1_to_a | input | 1 | Enable of B1-to-A storage |
| le_b2_to_a | input | 1 | Enable of B2-to-A storage |
| a_oe_n | input | 1 | Active-low driver enable, port A |
| b1_oe_n | input | 1 | Active-low driver enable, port B1 |
| b2_oe_n | input | 1 | Active-low driver enable, port B2 |
| a_drv_ext | input | 1 | Outside world drives pin A |
| a_in | input | DATA_W | Value driven onto pin A from outside |
| a_out | output | DATA_W | Value the block drives onto pin A |
| a_oe | output | 1 | Block drives pin A |
| b1_drv_ext | input | 1 | Outside world drives pin B1 |
| b1_in | input | DATA_W | Value driven onto pin B1 from outside |
| b1_out | output | DATA_W | Value the block drives onto pin B1 |
| b1_oe | output | 1 | Block drives pin B1 |
| b2_drv_ext | input | 1 | Outside world drives pin B2 |
| b2_in | input | DATA_W | Value driven onto pin B2 from outside |
| b2_out | output | DATA_W | Value the block drives onto pin B2 |
| b2_oe | output | 1 | Block drives pin B2 |

## Verification
The bench closes an element and then moves the source pin for several cycles. A design that sampled on every edge, or that captured one cycle late, would show the new value instead of the held one. It releases port A and then opens a forward element. A design without a keeper, or with a keeper that does not clear on reset, would deliver something other than the held level or zero. It lets the block drive A from a return element and loads that level into a forward element. A resolution that ignored the block's own drive would pass on the stale keeper value. It walks the three enables through the single-bank, dual-bank and released cases, and flips `sel` while both return elements hold different words. An inverted enable or a swapped select would show at once on `*_oe` or on `a_out`.

// File: rtl/mux_latch_exchanger_pkg.sv
package mux_latch_exchanger_pkg;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BANK_B1 = 0;
  localparam int unsigned BANK_B2 = 1;
endpackage

// File: rtl/bx_pad.sv
module bx_pad #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ext_drv,
  input  logic [W-1:0] ext_val,
  input  logic [W-1:0] core_val,
  input  logic         drv_en_n,
  output logic [W-1:0] level,
  output logic [W-1:0] pin_val,
  output logic         pin_oe
);
  logic [W-1:0] keep_q;

  assign pin_oe  = ~drv_en_n;
  assign pin_val = core_val;

  // Resolution order: the outside world first, then the block's own driver, then the keeper.
  always_comb begin
    if (ext_drv)     level = ext_val;
    else if (pin_oe) level = core_val;
    else             level = keep_q;
  end

  always_ff @(posedge clk) begin
    if (rst) keep_q <= '0;
    else     keep_q <= level;
  end
endmodule

// File: rtl/bx_latch.sv
module bx_latch #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Level-sensitive storage built from a clocked register. It has no reset.
  always_ff @(posedge clk) begin
    if (le) q <= d;
  end
endmodule

// File: rtl/mux_latch_exchanger.sv
module mux_latch_exchanger
  import mux_latch_exchanger_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              le_a_to_b1,
  input  logic              le_a_to_b2,
  input  logic              le_b1_to_a,
  input  logic              le_b2_to_a,
  input  logic              a_oe_n,
  input  logic              b1_oe_n,
  input  logic              b2_oe_n,
  input  logic              a_drv_ext,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic              b1_drv_ext,
  input  logic [DATA_W-1:0] b1_in,
  output logic [DATA_W-1:0] b1_out,
  output logic              b1_oe,
  input  logic              b2_drv_ext,
  input  logic [DATA_W-1:0] b2_in,
  output logic [DATA_W-1:0] b2_out,
  output logic              b2_oe
);
  localparam int unsigned NB = NUM_BANKS;

  logic [DATA_W-1:0] a_level;
  logic [DATA_W-1:0] a_core;
  logic [DATA_W-1:0] b_level [NB];
  logic [DATA_W-1:0] b_fwd_q [NB];
  logic [DATA_W-1:0] b_ret_q [NB];
  logic [DATA_W-1:0] b_ext   [NB];
  logic [DATA_W-1:0] b_pin   [NB];
  logic              b_pin_oe  [NB];
  logic              b_ext_drv [NB];
  logic              b_en_n    [NB];
  logic              le_fwd    [NB];
  logic              le_ret    [NB];

  assign b_ext[BANK_B1]     = b1_in;
  assign b_ext[BANK_B2]     = b2_in;
  assign b_ext_drv[BANK_B1] = b1_drv_ext;
  assign b_ext_drv[BANK_B2] = b2_drv_ext;
  assign b_en_n[BANK_B1]    = b1_oe_n;
  assign b_en_n[BANK_B2]    = b2_oe_n;
  assign le_fwd[BANK_B1]    = le_a_to_b1;
  assign le_fwd[BANK_B2]    = le_a_to_b2;
  assign le_ret[BANK_B1]    = le_b1_to_a;
  assign le_ret[BANK_B2]    = le_b2_to_a;

  // The return path to A: B1 element when sel is high, B2 element when sel is low.
  assign a_core = sel ? b_ret_q[BANK_B1] : b_ret_q[BANK_B2];

  bx_pad #(.W(DATA_W)) u_pad_a (
    .clk(clk), .rst(rst), .ext_drv(a_drv_ext), .ext_val(a_in),
    .core_val(a_core), .drv_en_n(a_oe_n),
    .level(a_level), .pin_val(a_out), .pin_oe(a_oe)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    bx_latch #(.W(DATA_W)) u_fwd (
      .clk(clk), .le(le_fwd[g]), .d(a_level), .q(b_fwd_q[g])
    );
    bx_latch #(.W(DATA_W)) u_ret (
      .clk(clk), .le(le_ret[g]), .d(b_level[g]), .q(b_ret_q[g])
    );
    bx_pad #(.W(DATA_W)) u_pad (
      .clk(clk), .rst(rst), .ext_drv(b_ext_drv[g]), .ext_val(b_ext[g]),
      .core_val(b_fwd_q[g]), .drv_en_n(b_en_n[g]),
      .level(b_level[g]), .pin_val(b_pin[g]), .pin_oe(b_pin_oe[g])
    );
  end

  assign b1_out = b_pin[BANK_B1];
  assign b2_out = b_pin[BANK_B2];
  assign b1_oe  = b_pin_oe[BANK_B1];
  assign b2_oe  = b_pin_oe[BANK_B2];
endmodule

// File: rtl/mux_latch_exchanger_chk.sv
module mux_latch_exchanger_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              le_a_to_b1,
  input logic              le_a_to_b2,
  input logic              le_b1_to_a,
  input logic              le_b2_to_a,
  input logic              a_oe_n,
  input logic              b1_oe_n,
  input logic              a_drv_ext,
  input logic [DATA_W-1:0] a_in,
  input logic [DATA_W-1:0] a_out,
  input logic              a_oe,
  input logic [DATA_W-1:0] b1_out,
  input logic [DATA_W-1:0] b2_out,
  input logic              b1_oe
);
  // R1
  fwd_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (le_a_to_b1 && a_drv_ext) |=> (b1_out == $past(a_in)));

  // R2
  fwd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !le_a_to_b1 |=> $stable(b1_out));

  // R3
  bank_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (le_a_to_b2 && !le_a_to_b1) |=> $stable(b1_out));

  // R4
  ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!le_b1_to_a && !le_b2_to_a) |=> (sel == $past(sel)) |-> $stable(a_out));

  // R5
  oe_low_active_chk: assert property (@(posedge clk) disable iff (rst)
    (a_oe_n |-> !a_oe) and (b1_oe_n |-> !b1_oe));

  // R6
  keeper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_drv_ext && !a_oe && le_a_to_b1 &&
     $past(!a_drv_ext && !a_oe && le_a_to_b1 && !rst)) |=> $stable(b1_out));
endmodule

bind mux_latch_exchanger mux_latch_exchanger_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sel(sel),
  .le_a_to_b1(le_a_to_b1), .le_a_to_b2(le_a_to_b2),
  .le_b1_to_a(le_b1_to_a), .le_b2_to_a(le_b2_to_a),
  .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .a_drv_ext(a_drv_ext), .a_in(a_in),
  .a_out(a_out), .a_oe(a_oe), .b1_out(b1_out), .b2_out(b2_out), .b1_oe(b1_oe)
);

// File: tb/sim_mux_latch_exchanger.sv
module sim_mux_latch_exchanger;
  localparam int W = 12;

  logic clk = 0, rst = 1, sel = 0;
  logic le_a_to_b1 = 0, le_a_to_b2 = 0, le_b1_to_a = 0, le_b2_to_a = 0;
  logic a_oe_n = 1, b1_oe_n = 1, b2_oe_n = 1;
  logic a_drv_ext = 0, b1_drv_ext = 0, b2_drv_ext = 0;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_oe, b1_oe, b2_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    string        tag;
    int           kind;  // 0 a_out, 1 b1_out, 2 b2_out, 3 {a_oe,b1_oe,b2_oe}
    logic [W-1:0] exp;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  mux_latch_exchanger #(.DATA_W(W)) u0 (
    .clk(clk), .rst(rst), .sel(sel),
    .le_a_to_b1(le_a_to_b1), .le_a_to_b2(le_a_to_b2),
    .le_b1_to_a(le_b1_to_a), .le_b2_to_a(le_b2_to_a),
    .a_oe_n(a_oe_n), .b1_oe_n(b1_oe_n), .b2_oe_n(b2_oe_n),
    .a_drv_ext(a_drv_ext), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b1_drv_ext(b1_drv_ext), .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_drv_ext(b2_drv_ext), .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe)
  );

  task automatic expect_item(input string tag, input int kind, input logic [W-1:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sb.push_back(it);
  endtask

  // Monitor: results of the inputs set at a falling edge appear after the next rising edge.
  always @(posedge clk) begin
    #2;
    while (sb.size() > 0) begin
      item_t it;
      logic [W-1:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = a_out;
        1: act = b1_out;
        2: act = b2_out;
        default: act = {{(W-3){1'b0}}, a_oe, b1_oe, b2_oe};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    expect_item("R5 reset oe", 3, 12'h000);
    @(negedge clk);
    // R6: keeper on A clears to 0 on reset
    le_a_to_b1 = 1;
    expect_item("R6 keeper reset", 1, 12'h000);
    @(negedge clk);
    a_drv_ext = 1; a_in = 12'hABC; b1_oe_n = 0;
    expect_item("R1 follow", 1, 12'hABC);
    expect_item("R5 b1 oe", 3, 12'h002);
    @(negedge clk);
    a_in = 12'h123;
    expect_item("R1 follow 2", 1, 12'h123);
    @(negedge clk);
    le_a_to_b1 = 0; a_in = 12'h555;
    expect_item("R2 hold", 1, 12'h123);
    @(negedge clk);
    a_in = 12'h777;
    expect_item("R2 hold 2", 1, 12'h123);
    @(negedge clk);
    le_a_to_b2 = 1; a_in = 12'h2A5; b2_oe_n = 0;
    expect_item("R3 b2 load", 2, 12'h2A5);
    expect_item("R3 b1 untouched", 1, 12'h123);
    @(negedge clk);
    le_a_to_b2 = 0; a_drv_ext = 0; le_a_to_b1 = 1;
    expect_item("R6 keeper hold", 1, 12'h2A5);
    @(negedge clk);
    le_a_to_b1 = 0; b1_oe_n = 1; b2_oe_n = 1;
    b1_drv_ext = 1; b1_in = 12'h0F0; b2_drv_ext = 1; b2_in = 12'hF0F;
    le_b1_to_a = 1; le_b2_to_a = 1; sel = 1; a_oe_n = 0;
    expect_item("R4 sel1", 0, 12'h0F0);
    expect_item("R5 a oe", 3, 12'h004);
    @(negedge clk);
    sel = 0;
    expect_item("R4 sel0", 0, 12'hF0F);
    @(negedge clk);
    le_b1_to_a = 0; le_b2_to_a = 0; b1_in = 12'h111; b2_in = 12'h222; sel = 1;
    expect_item("R2 ret hold sel1", 0, 12'h0F0);
    @(negedge clk);
    sel = 0;
    expect_item("R2 ret hold sel0", 0, 12'hF0F);
    @(negedge clk);
    a_oe_n = 1; b1_oe_n = 0; b2_oe_n = 1;
    expect_item("R5 bank b1 only", 3, 12'h002);
    @(negedge clk);
    b1_oe_n = 0; b2_oe_n = 0;
    expect_item("R5 both banks", 3, 12'h003);
    @(negedge clk);
    b1_oe_n = 1; b2_oe_n = 1; b1_drv_ext = 0; b2_drv_ext = 0;
    a_oe_n = 0; le_a_to_b1 = 1;
    expect_item("R7 own drive", 1, 12'hF0F);
    @(negedge clk);
    le_a_to_b1 = 0; a_oe_n = 1; le_a_to_b2 = 1;
    expect_item("R7 keeper after release", 2, 12'hF0F);
    @(negedge clk);
    le_a_to_b2 = 0; le_b1_to_a = 1; sel = 1; a_oe_n = 0;
    expect_item("R6 b1 keeper", 0, 12'h111);
    @(negedge clk);
    le_b1_to_a = 0;
    @(negedge clk);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule